// File: doc/BRIEF.md
# Four-Channel Timer Snapshot Unit

This block keeps four 16-bit holding registers, each of which can take a snapshot of a free-running timer value. Every channel is set to one of two trigger sources. In pin mode, a recognised transition on the channel's input pin starts the capture. In write mode, a bus write to the channel's low byte starts it. All sampling and triggering is tied to a one-clock machine-cycle strobe. A capture always lands on the strobe after the one at which its trigger was seen.

Pin-triggered captures raise a per-channel interrupt request flag. The flag stays set until software clears it with a write-one-to-clear access. Channels 1 to 3 react only to rising pin edges. Channel 0 reacts to the edge picked by a select input. Software reads each snapshot one byte at a time over a small register bus. Reads have no side effects.

Top module: `tcap_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all four snapshots and all four interrupt flags are cleared to zero.
- R2: A capture stores the full 16-bit `timer_val` present on the strobe clock of the capture. Reading byte address 2n returns bits 7:0 of channel n, and address 2n+1 returns bits 15:8.
- R3: Pins are sampled only on clocks where `mc_en` is high. An edge is recognised at a strobe when the new sample differs from the previous sample in the chosen direction. The capture happens at the next strobe, and no snapshot changes on a clock without `mc_en`.
- R4: With `mode_sel[n]`=0, channels 1 to 3 capture only after a low-to-high pin transition. A high-to-low transition leaves the snapshot unchanged.
- R5: With `mode_sel[0]`=0, channel 0 triggers on a falling transition when `ch0_rise`=0 and on a rising transition when `ch0_rise`=1.
- R6: With `mode_sel[n]`=1, a write to address 2n arms a capture that happens at the first strobe on a later clock. The written data is discarded, and pin transitions on that channel are ignored.
- R7: A pin-mode capture sets bit n of `irq_flags`. A write-mode capture never sets a flag.
- R8: Address 8 reads the flags in bits 3:0. A write there clears each flag whose data bit is 1 and leaves the flags whose data bit is 0. A flag set and a clear on the same clock leave the flag set.
- R9: Writes to a high byte (address 2n+1), writes to address 8, reads, and low-byte writes to a channel in pin mode never trigger a capture.
- R10: When a channel's mode bit changes, its sample history is loaded from the present pin level and any pending trigger is dropped. A pin held high across the change therefore creates no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_en | input | 1 | One-clock machine-cycle strobe |
| timer_val | input | 16 | Free-running timer value |
| pin_in | input | 4 | Channel input pins |
| mode_sel | input | 4 | Per-channel trigger source: 0 pin, 1 write |
| ch0_rise | input | 1 | Channel 0 edge select: 0 falling, 1 rising |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| irq_flags | output | 4 | Interrupt request flags |

## Verification
Directed patterns apply single rising and falling pulses on each channel. They check that channel 0's selected polarity is honoured and that the fixed rising polarity of channels 1 to 3 is honoured. A write-mode sequence separates low-byte writes, which arm a capture, from high-byte and flag writes, which must not, and it confirms that pins are ignored in that mode. A mode switch with the pin held high tells correct history reloading apart from a false edge. A long random run then mixes pin toggles, writes to random addresses, and mode and polarity changes at random phases against the strobe. This tests strobe qualification and the one-strobe capture delay, and every byte and flag is compared to a model after each clock.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
    localparam int unsigned CH_N   = 4;
    localparam int unsigned TMR_W  = 16;
    localparam int unsigned BUS_DW = 8;
    localparam int unsigned BUS_AW = 4;
    localparam int unsigned BYTES_PER_CH = TMR_W / BUS_DW;
    localparam int unsigned FLAG_ADDR = CH_N * BYTES_PER_CH;

    typedef enum logic {
        TRIG_PIN   = 1'b0,
        TRIG_WRITE = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic       hist;
        logic       edge_pend;
        logic       wr_pend;
        trig_mode_e mode_q;
    } ch_state_t;

    function automatic logic edge_hit(input logic prev, input logic now, input logic rising);
        return rising ? (!prev && now) : (prev && !now);
    endfunction
endpackage

// File: rtl/tcap_trigger.sv
module tcap_trigger
    import tcap_pkg::*;
#(
    parameter bit POL_SELECTABLE = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe,
    input  logic       pin,
    input  trig_mode_e mode,
    input  logic       rise_sel,
    input  logic       lo_wr,
    output logic       cap_fire,
    output logic       pin_set
);
    ch_state_t st;
    logic      rising;
    logic      mode_same;
    logic      arm_wr;

    generate
        if (POL_SELECTABLE) begin : g_sel
            assign rising = rise_sel;
        end else begin : g_fixed
            logic unused_rise;
            assign unused_rise = rise_sel;
            assign rising = 1'b1;
        end
    endgenerate

    assign mode_same = (mode == st.mode_q);
    assign arm_wr    = lo_wr && (mode == TRIG_WRITE);

    always_ff @(posedge clk) begin
        if (rst || !mode_same) begin
            st.hist      <= pin;
            st.edge_pend <= 1'b0;
            st.wr_pend   <= 1'b0;
            st.mode_q    <= mode;
        end else if (strobe) begin
            st.hist      <= pin;
            st.edge_pend <= (mode == TRIG_PIN) && edge_hit(st.hist, pin, rising);
            st.wr_pend   <= arm_wr;
        end else if (arm_wr) begin
            st.wr_pend   <= 1'b1;
        end
    end

    assign cap_fire = strobe && mode_same && (st.edge_pend || st.wr_pend);
    assign pin_set  = cap_fire && st.edge_pend;

    // R10
    hist_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != st.mode_q) |=> (st.hist == $past(pin)));

    // R7
    pend_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(st.edge_pend && st.wr_pend));

    // R9
    wr_arm_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st.wr_pend) |-> $past(lo_wr));
endmodule

// File: rtl/tcap_hold.sv
module tcap_hold #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] tval,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= tval;
        end
    end
endmodule

// File: rtl/tcap_regfile.sv
module tcap_regfile
    import tcap_pkg::*;
#(
    parameter int unsigned N_CH = CH_N,
    parameter int unsigned T_W  = TMR_W,
    parameter int unsigned D_W  = BUS_DW,
    parameter int unsigned A_W  = BUS_AW
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_CH-1:0][T_W-1:0] caps,
    input  logic [N_CH-1:0]          pin_set,
    input  logic                     bus_wr,
    input  logic [A_W-1:0]           bus_addr,
    input  logic [D_W-1:0]           bus_wdata,
    output logic [D_W-1:0]           bus_rdata,
    output logic [N_CH-1:0]          lo_wr,
    output logic [N_CH-1:0]          flags
);
    localparam int unsigned BPC    = T_W / D_W;
    localparam logic [A_W-1:0] FLAG_A = A_W'(N_CH * BPC);

    logic flag_wr;
    logic unused_wdata;

    assign flag_wr      = bus_wr && (bus_addr == FLAG_A);
    assign unused_wdata = ^bus_wdata;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == FLAG_A) begin
            bus_rdata = D_W'(flags);
        end else begin
            for (int c = 0; c < N_CH; c++) begin
                for (int b = 0; b < BPC; b++) begin
                    if (bus_addr == A_W'(c * BPC + b)) begin
                        bus_rdata = caps[c][b*D_W +: D_W];
                    end
                end
            end
        end
    end

    genvar c;
    generate
        for (c = 0; c < N_CH; c++) begin : g_ch
            assign lo_wr[c] = bus_wr && (bus_addr == A_W'(c * BPC));

            always_ff @(posedge clk) begin
                if (rst) begin
                    flags[c] <= 1'b0;
                end else begin
                    flags[c] <= pin_set[c] || (flags[c] && !(flag_wr && bus_wdata[c]));
                end
            end

            // R8
            flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
                (flag_wr && bus_wdata[c] && !pin_set[c]) |=> !flags[c]);

            // R8
            flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (flags[c] && !(flag_wr && bus_wdata[c])) |=> flags[c]);
        end
    endgenerate
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
    import tcap_pkg::*;
#(
    parameter int unsigned N_CH = CH_N,
    parameter int unsigned T_W  = TMR_W,
    parameter int unsigned D_W  = BUS_DW,
    parameter int unsigned A_W  = BUS_AW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mc_en,
    input  logic [T_W-1:0]  timer_val,
    input  logic [N_CH-1:0] pin_in,
    input  logic [N_CH-1:0] mode_sel,
    input  logic            ch0_rise,
    input  logic            bus_wr,
    input  logic [A_W-1:0]  bus_addr,
    input  logic [D_W-1:0]  bus_wdata,
    output logic [D_W-1:0]  bus_rdata,
    output logic [N_CH-1:0] irq_flags
);
    logic [N_CH-1:0][T_W-1:0] caps;
    logic [N_CH-1:0]          fire;
    logic [N_CH-1:0]          pin_set;
    logic [N_CH-1:0]          lo_wr;

    genvar c;
    generate
        for (c = 0; c < N_CH; c++) begin : g_ch
            tcap_trigger #(
                .POL_SELECTABLE(c == 0)
            ) u_trig (
                .clk      (clk),
                .rst      (rst),
                .strobe   (mc_en),
                .pin      (pin_in[c]),
                .mode     (trig_mode_e'(mode_sel[c])),
                .rise_sel (ch0_rise),
                .lo_wr    (lo_wr[c]),
                .cap_fire (fire[c]),
                .pin_set  (pin_set[c])
            );

            tcap_hold #(
                .WIDTH(T_W)
            ) u_hold (
                .clk  (clk),
                .rst  (rst),
                .load (fire[c]),
                .tval (timer_val),
                .q    (caps[c])
            );

            // R3
            cap_strobe_only_chk: assert property (@(posedge clk) disable iff (rst)
                !$past(mc_en) |-> $stable(caps[c]));

            // R7
            flag_src_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(irq_flags[c]) |-> ($past(mc_en) && !$past(mode_sel[c])));
        end
    endgenerate

    tcap_regfile #(
        .N_CH(N_CH),
        .T_W (T_W),
        .D_W (D_W),
        .A_W (A_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .caps      (caps),
        .pin_set   (pin_set),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lo_wr     (lo_wr),
        .flags     (irq_flags)
    );
endmodule

// File: tb/tcap_unit_tb.sv
`timescale 1ns/1ps
module tcap_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mc = 1'b0;
    logic [15:0] tmr = 16'h0000;
    logic [3:0]  pin = 4'h0;
    logic [3:0]  mode = 4'h0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic [3:0]  irq;

    int    n_tests = 0;
    int    n_fail = 0;
    int    cyc_n = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    logic [15:0] m_cap [4];
    logic [3:0]  m_flag, m_hist, m_ep, m_wp, m_mq;

    always #2 clk = ~clk;

    tcap_unit u_dut (
        .clk(clk), .rst(rst), .mc_en(mc), .timer_val(tmr), .pin_in(pin),
        .mode_sel(mode), .ch0_rise(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_flags(irq)
    );

    function automatic logic edge_seen(input logic prev, input logic now, input logic rising);
        return rising ? (!prev && now) : (prev && !now);
    endfunction

    // Reference model from the requirements
    always @(posedge clk) begin
        for (int c = 0; c < 4; c++) begin
            logic set_f, clr, nw, det, rz;
            set_f = 1'b0;
            clr   = wr && (addr == 4'd8) && wdata[c];
            if (rst) begin
                m_hist[c] = pin[c]; m_ep[c] = 1'b0; m_wp[c] = 1'b0;
                m_mq[c] = mode[c]; m_cap[c] = 16'h0; m_flag[c] = 1'b0;
            end else begin
                if (mode[c] != m_mq[c]) begin
                    m_hist[c] = pin[c]; m_ep[c] = 1'b0; m_wp[c] = 1'b0; m_mq[c] = mode[c];
                end else begin
                    nw = wr && (addr == 4'(2*c)) && mode[c];
                    if (mc) begin
                        if (m_ep[c] || m_wp[c]) begin
                            m_cap[c] = tmr;
                            set_f = m_ep[c];
                        end
                        rz  = (c == 0) ? sel : 1'b1;
                        det = !mode[c] && edge_seen(m_hist[c], pin[c], rz);
                        m_ep[c] = det; m_wp[c] = nw; m_hist[c] = pin[c];
                    end else if (nw) begin
                        m_wp[c] = 1'b1;
                    end
                end
                m_flag[c] = set_f || (m_flag[c] && !clr);
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk({cur_req, " irq flags R7"}, {12'h0, irq}, {12'h0, m_flag});
        for (int a = 0; a < 8; a++) begin
            addr = 4'(a);
            #0.1;
            // R2 byte readback
            chk({cur_req, " snapshot byte R2"}, {8'h0, rdata}, {8'h0, m_cap[a/2][(a%2)*8 +: 8]});
        end
        addr = 4'd8;
        #0.1;
        chk({cur_req, " flag reg R8"}, {8'h0, rdata}, {12'h0, m_flag});
    endtask

    task automatic tick();
        @(negedge clk);
        check_all();
        wr = 1'b0;
        cyc_n++;
        mc = (cyc_n % 4 == 0);
        tmr = tmr + 16'h0123;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        tick();
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        ticks(3);
        rst = 1'b0;
        // R1 explicit reset state
        for (int a = 0; a < 9; a++) begin
            addr = 4'(a);
            #0.1;
            chk("R1 reset byte", {8'h0, rdata}, 16'h0);
        end
        chk("R1 reset flags", {12'h0, irq}, 16'h0);

        cur_req = "R5";
        pin[0] = 1'b1; ticks(9);
        pin[0] = 1'b0; ticks(9);
        chk("R5 falling edge flag", {15'h0, irq[0]}, 16'h1);
        bus_write(4'd8, 8'h01); ticks(2);
        sel = 1'b1; ticks(2);
        pin[0] = 1'b1; ticks(9);
        chk("R5 rising edge flag", {15'h0, irq[0]}, 16'h1);

        cur_req = "R4";
        pin[1] = 1'b1; ticks(9);
        chk("R4 rising edge flag", {15'h0, irq[1]}, 16'h1);
        bus_write(4'd8, 8'h02);
        pin[1] = 1'b0; ticks(9);
        chk("R4 falling edge ignored", {15'h0, irq[1]}, 16'h0);

        cur_req = "R6";
        mode[2] = 1'b1; ticks(4);
        bus_write(4'd4, 8'hA5); ticks(8);
        pin[2] = 1'b1; ticks(9);
        pin[2] = 1'b0; ticks(9);
        chk("R6 write capture raises no flag", {15'h0, irq[2]}, 16'h0);

        cur_req = "R9";
        bus_write(4'd5, 8'h3C); ticks(8);
        bus_write(4'd8, 8'h00); ticks(8);
        bus_write(4'd6, 8'hFF); ticks(8);

        cur_req = "R8";
        pin[3] = 1'b1; ticks(9);
        bus_write(4'd8, 8'hF0); ticks(2);
        chk("R8 zero bits keep flag", {15'h0, irq[3]}, 16'h1);
        bus_write(4'd8, 8'h08); ticks(1);
        chk("R8 one clears flag", {15'h0, irq[3]}, 16'h0);

        cur_req = "R10";
        mode[3] = 1'b1; ticks(3);
        pin[3] = 1'b0; ticks(5);
        pin[3] = 1'b1; ticks(5);
        mode[3] = 1'b0; ticks(12);
        chk("R10 no false edge", {15'h0, irq[3]}, 16'h0);

        cur_req = "R3";
        for (int i = 0; i < 4000; i++) begin
            tick();
            if ($urandom_range(0, 2) == 0) pin = pin ^ 4'($urandom_range(0, 15));
            if ($urandom_range(0, 59) == 0) mode = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 79) == 0) sel = ~sel;
            if ($urandom_range(0, 3) == 0) begin
                wr = 1'b1;
                addr = 4'($urandom_range(0, 8));
                wdata = 8'($urandom_range(0, 255));
            end
        end
        ticks(2);

        done = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        done = 1'b1;
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule